// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Lookup

This block looks a virtual address up against every entry of a fully associative translation table in one pass. Each entry is a pair of 64-bit words: a tag carrying the virtual page number and the 13-bit context, and a translation word carrying the valid bit, a page-size code, the physical page number and the permission bits. Every entry applies its own page mask, so 8 KB, 64 KB, 512 KB and 4 MB pages can sit side by side in the table.

A lookup request carries the virtual address, the current context, a user-mode flag and a write flag. One clock later the block reports exactly one of three outcomes: a hit with the physical address and the page's write permission, a permission fault (privilege, or write protection on the data side), or a miss. A miss comes with a ready-made tag word for the miss handler. The parameter `IS_INSTR` selects the instruction-side variant, which ignores the write flag and checks only privilege.

The entry contents reach the block as flat vectors, so the owner of the table can keep it in flops or in any array it likes. Writing entries into the table is handled outside this block.

Top module: `tlb_lookup`

## Requirements
- R1: An entry matches only when its translation word bit 63 is 1, its tag bits 12:0 equal `ctx_i`, and `va_i` equals its tag in every bit that the entry's page mask keeps.
- R2: Translation word bits 62:61 give the page-size code: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB. The page mask keeps the bits from 13 + 3*code up to 63. Address bits below that position do not take part in the match.
- R3: On a hit, `pa_o` bits 40:13 equal the translation word's bits wherever the mask keeps a bit and the address's bits wherever it does not. `pa_o` bits 12:0 are zero, and all of `pa_o` is zero when there is no hit.
- R4: When several entries match, the result comes from the entry with the lowest index.
- R5: When translation word bit 2 (privileged) of the winning entry is set and `user_i` is 1, `priv_fault_o` is raised and `hit_o` stays low.
- R6: In the data variant, a write to a winning entry whose translation word bit 1 (writable) is clear raises `wp_fault_o` and keeps `hit_o` low. Whenever an entry wins, `writable_o` shows that entry's bit 1.
- R7: In the instruction variant, `write_i` has no effect: `wp_fault_o` stays low, and the result depends only on the match and on privilege.
- R8: When no entry matches, `miss_o` is 1 and `miss_tag_o` holds `va_i` bits 63:13 above `ctx_i` in bits 12:0.
- R9: Results appear one clock after the request. `vld_o` follows `req_valid_i` with one cycle of delay, and every result output is zero in a cycle where `vld_o` is low.
- R10: At most one of `hit_o`, `miss_o` and the fault group (`priv_fault_o` or `wp_fault_o`) is set in any cycle. The two fault flags may be set together.
- R11: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request strobe |
| va_i | input | 64 | Virtual address |
| ctx_i | input | 13 | Current context |
| user_i | input | 1 | Access is made in user mode |
| write_i | input | 1 | Access is a write |
| tags_i | input | N_ENTRIES*64 | Entry tags, entry i at bits i*64 +: 64 |
| ttes_i | input | N_ENTRIES*64 | Entry translation words, entry i at bits i*64 +: 64 |
| vld_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation succeeded |
| pa_o | output | 41 | Physical address (bits 40:13 significant) |
| writable_o | output | 1 | Winning entry allows writes |
| priv_fault_o | output | 1 | User access to a privileged page |
| wp_fault_o | output | 1 | Write to a non-writable page |
| miss_o | output | 1 | No entry matched |
| miss_tag_o | output | 64 | Page number and context of the missed access |

## Verification
On every cycle, the embedded properties check that the three outcomes exclude one another, that results come exactly one cycle after a request and stay quiet otherwise, that a privilege fault only follows a user access, that the miss tag carries the requesting context, and that a data-side hit on a write only comes from a writable page. Whether the right entry wins, the physical address merge for each page size, the page-boundary edges, and the correct choice between hit, fault and miss all depend on table contents. Only the bench's sweeps show these, running against its own arithmetic model on both variants.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam int WORD_W  = 64;
  localparam int CTX_W   = 13;
  localparam int PG_LSB  = 13;
  localparam int PA_MSB  = 40;
  localparam int PA_W    = PA_MSB + 1;

  // translation word bit positions
  localparam int TV_BIT  = 63;
  localparam int SZ_HI   = 62;
  localparam int SZ_LO   = 61;
  localparam int PRV_BIT = 2;
  localparam int WR_BIT  = 1;

  typedef struct packed {
    logic [1:0]             size;
    logic [PA_MSB:PG_LSB]   ppn;
    logic                   priv;
    logic                   wr;
  } tte_sel_t;

  // keep-mask for a page-size code: ones from bit 13+3*code upward
  function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] code);
    logic [WORD_W-1:0] m;
    m = {{(WORD_W-PG_LSB){1'b1}}, {PG_LSB{1'b0}}};
    return m << (3 * code);
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_lookup_pkg::*;
(
  input  logic                    valid_i,
  input  logic [1:0]              size_i,
  input  logic [WORD_W-1:0]       tag_i,
  input  logic [WORD_W-1:PG_LSB]  vpn_i,
  input  logic [CTX_W-1:0]        ctx_i,
  output logic                    match_o
);
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:PG_LSB] diff;

  always_comb begin
    mask    = page_mask(size_i);
    diff    = (vpn_i ^ tag_i[WORD_W-1:PG_LSB]) & mask[WORD_W-1:PG_LSB];
    match_o = valid_i && (tag_i[CTX_W-1:0] == ctx_i) && (diff == '0);
  end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] match_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  // scanning downward leaves the lowest matching index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter bit IS_INSTR  = 1'b0,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int ARR_W = N_ENTRIES * WORD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [WORD_W-1:0]     va_i,
  input  logic [CTX_W-1:0]      ctx_i,
  input  logic                  user_i,
  input  logic                  write_i,
  input  logic [ARR_W-1:0]      tags_i,
  input  logic [ARR_W-1:0]      ttes_i,
  output logic                  vld_o,
  output logic                  hit_o,
  output logic [PA_W-1:0]       pa_o,
  output logic                  writable_o,
  output logic                  priv_fault_o,
  output logic                  wp_fault_o,
  output logic                  miss_o,
  output logic [WORD_W-1:0]     miss_tag_o
);
  logic [N_ENTRIES-1:0] match;
  tte_sel_t             fields [N_ENTRIES];
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  tte_sel_t             win;
  logic [WORD_W-1:0]    win_mask;
  logic [PA_MSB:PG_LSB] pa_pg;
  logic                 pf_c, wp_c, hit_c;

  // bits of the address and translation word that take no part
  logic unused_bits;
  assign unused_bits = ^{va_i[PG_LSB-1:0], ttes_i};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [WORD_W-1:0] tte;
    assign tte = ttes_i[g*WORD_W +: WORD_W];
    assign fields[g] = '{size: tte[SZ_HI:SZ_LO],
                         ppn:  tte[PA_MSB:PG_LSB],
                         priv: tte[PRV_BIT],
                         wr:   tte[WR_BIT]};
    tlb_entry_match u_match (
      .valid_i (tte[TV_BIT]),
      .size_i  (tte[SZ_HI:SZ_LO]),
      .tag_i   (tags_i[g*WORD_W +: WORD_W]),
      .vpn_i   (va_i[WORD_W-1:PG_LSB]),
      .ctx_i   (ctx_i),
      .match_o (match[g])
    );
  end

  tlb_prio_sel #(.N_ENTRIES(N_ENTRIES)) u_sel (
    .match_i (match),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_comb begin
    win      = fields[win_idx];
    win_mask = page_mask(win.size);
    pa_pg    = (win.ppn & win_mask[PA_MSB:PG_LSB]) |
               (va_i[PA_MSB:PG_LSB] & ~win_mask[PA_MSB:PG_LSB]);
  end

  if (IS_INSTR) begin : g_instr
    logic unused_write;
    assign unused_write = write_i;
    assign wp_c = 1'b0;
  end else begin : g_data
    assign wp_c = found && write_i && !win.wr;
  end

  assign pf_c  = found && user_i && win.priv;
  assign hit_c = found && !pf_c && !wp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      hit_o        <= 1'b0;
      pa_o         <= '0;
      writable_o   <= 1'b0;
      priv_fault_o <= 1'b0;
      wp_fault_o   <= 1'b0;
      miss_o       <= 1'b0;
      miss_tag_o   <= '0;
    end else begin
      vld_o        <= req_valid_i;
      hit_o        <= req_valid_i && hit_c;
      pa_o         <= (req_valid_i && hit_c) ? {pa_pg, {PG_LSB{1'b0}}} : '0;
      writable_o   <= req_valid_i && found && win.wr;
      priv_fault_o <= req_valid_i && pf_c;
      wp_fault_o   <= req_valid_i && wp_c;
      miss_o       <= req_valid_i && !found;
      miss_tag_o   <= (req_valid_i && !found) ?
                      {va_i[WORD_W-1:PG_LSB], ctx_i} : '0;
    end
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vld_o);
  // R9
  vld_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !vld_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !(hit_o || miss_o || priv_fault_o || wp_fault_o || writable_o));
  // R10
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, priv_fault_o || wp_fault_o}));
  // R5
  priv_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault_o |-> $past(user_i));
  // R8
  miss_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> miss_tag_o[CTX_W-1:0] == $past(ctx_i));
  // R3
  pa_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> pa_o == '0);

  if (!IS_INSTR) begin : g_data_chk
    // R6
    write_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && $past(write_i)) |-> writable_o);
  end
endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  localparam int N  = 8;
  localparam int W  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [63:0]   va = '0;
  logic [12:0]   ctx = '0;
  logic          user = 1'b0, wr = 1'b0;
  logic [63:0]   tag_m [N];
  logic [63:0]   tte_m [N];
  logic [N*W-1:0] tags_f, ttes_f;

  always_comb
    for (int i = 0; i < N; i++) begin
      tags_f[i*W +: W] = tag_m[i];
      ttes_f[i*W +: W] = tte_m[i];
    end

  logic        d_vld, d_hit, d_wr, d_pf, d_wp, d_miss;
  logic [40:0] d_pa;
  logic [63:0] d_mt;
  logic        i_vld, i_hit, i_wr, i_pf, i_wp, i_miss;
  logic [40:0] i_pa;
  logic [63:0] i_mt;

  tlb_lookup #(.N_ENTRIES(N), .IS_INSTR(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va),
    .ctx_i(ctx), .user_i(user), .write_i(wr), .tags_i(tags_f), .ttes_i(ttes_f),
    .vld_o(d_vld), .hit_o(d_hit), .pa_o(d_pa), .writable_o(d_wr),
    .priv_fault_o(d_pf), .wp_fault_o(d_wp), .miss_o(d_miss), .miss_tag_o(d_mt));

  tlb_lookup #(.N_ENTRIES(N), .IS_INSTR(1'b1)) uut_ins (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va),
    .ctx_i(ctx), .user_i(user), .write_i(wr), .tags_i(tags_f), .ttes_i(ttes_f),
    .vld_o(i_vld), .hit_o(i_hit), .pa_o(i_pa), .writable_o(i_wr),
    .priv_fault_o(i_pf), .wp_fault_o(i_wp), .miss_o(i_miss), .miss_tag_o(i_mt));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // packed result: vld hit wr pf wp miss | pa(41) | miss_tag(64)
  function automatic logic [110:0] model(input logic [63:0] a, input logic [12:0] c,
                                         input logic u, input logic w,
                                         input logic rv, input bit instr);
    logic found = 1'b0;
    logic [63:0] t = '0, g = '0, m = '0;
    logic pf, wp, ht;
    logic [63:0] pa;
    if (!rv) return '0;
    for (int i = 0; i < N; i++) begin
      logic [63:0] mk;
      mk = 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(tte_m[i][62:61]));
      if (!found && tte_m[i][63] && tag_m[i][12:0] == c && ((a ^ tag_m[i]) & mk) == 0) begin
        found = 1'b1; t = tte_m[i]; g = tag_m[i]; m = mk;
      end
    end
    if (!found) return {1'b1, 4'b0, 1'b1, 41'd0, a[63:13], c};
    pf = t[2] && u;
    wp = !instr && w && !t[1];
    ht = !pf && !wp;
    pa = ((t & m) | (a & ~m)) & 64'h0000_01FF_FFFF_E000;
    if (g == 64'h1) pa = pa; // keep tag referenced
    return {1'b1, ht, t[1], pf, wp, 1'b0, ht ? pa[40:0] : 41'd0, 64'd0};
  endfunction

  task automatic cmp(input string rq, input logic [110:0] got, input logic [110:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic run(input string rq, input logic [63:0] a, input logic [12:0] c,
                     input logic u, input logic w, input logic rv = 1'b1);
    logic [110:0] ed, ei;
    @(negedge clk);
    va = a; ctx = c; user = u; wr = w; req_valid = rv;
    ed = model(a, c, u, w, rv, 1'b0);
    ei = model(a, c, u, w, rv, 1'b1);
    @(posedge clk); #1;
    cmp({rq, " data"}, {d_vld, d_hit, d_wr, d_pf, d_wp, d_miss, d_pa, d_mt}, ed);
    cmp({rq, " instr"}, {i_vld, i_hit, i_wr, i_pf, i_wp, i_miss, i_pa, i_mt}, ei);
    // R10 outcome exclusion on both variants
    n_chk++;
    if ((d_hit + d_miss + (d_pf | d_wp)) > 1 || (i_hit + i_miss + (i_pf | i_wp)) > 1) begin
      n_fail++;
      $display("FAIL R10 d=%b%b%b i=%b%b%b exp=onehot0", d_hit, d_miss, d_pf|d_wp,
               i_hit, i_miss, i_pf|i_wp);
    end
  endtask

  function automatic logic [63:0] mk_tte(input logic [1:0] sz, input logic [63:0] pa,
                                         input logic prv, input logic w);
    return {1'b1, sz, 48'd0, 13'd0} | (pa & 64'h0000_01FF_FFFF_E000) |
           {61'd0, prv, w, 1'b0};
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < N; i++) begin tag_m[i] = '0; tte_m[i] = '0; end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_tbl();
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    cmp("R11 data", {d_vld, d_hit, d_wr, d_pf, d_wp, d_miss, d_pa, d_mt}, '0);
    cmp("R11 instr", {i_vld, i_hit, i_wr, i_pf, i_wp, i_miss, i_pa, i_mt}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R9 idle request gives quiet outputs
    run("R9 idle", 64'h1234_5678_9ABC_DEF0, 13'h5, 1'b0, 1'b0, 1'b0);
    // R8 empty table misses
    run("R8 empty", 64'hFFFF_8000_0040_2000, 13'h1ABC, 1'b1, 1'b1);

    // R2 R3 page-size sweep with boundary offsets
    for (int sz = 0; sz < 4; sz++) begin
      logic [63:0] base, span;
      clear_tbl();
      span = 64'h1 << (13 + 3 * sz);
      base = 64'h0000_7A00_0000_0000 + span * 5;
      tag_m[3] = base | 64'h0033;
      tte_m[3] = mk_tte(sz[1:0], 64'h0000_0155_5540_0000 | (span * 3), 1'b0, 1'b1);
      for (int k = 0; k < 6; k++) begin
        logic [63:0] off;
        case (k)
          0: off = 0;
          1: off = span - 1;
          2: off = span >> 1;
          3: off = 64'h1FFF;
          4: off = span;           // next page: miss (R8)
          default: off = -64'sd1;  // previous page: miss
        endcase
        run($sformatf("R2 R3 sz%0d off%0d", sz, k), base + off, 13'h0033, 1'b0, 1'b0);
      end
      // R1 context mismatch and valid bit clear
      run("R1 ctx", base, 13'h0032, 1'b0, 1'b0);
      tte_m[3][63] = 1'b0;
      run("R1 invalid", base, 13'h0033, 1'b0, 1'b0);
    end

    // R4 lowest index wins, including different page sizes overlapping
    clear_tbl();
    tag_m[2] = 64'h0000_4000_0000_0007; tte_m[2] = mk_tte(2'd0, 64'h0000_0011_1111_0000, 1'b0, 1'b1);
    tag_m[5] = 64'h0000_4000_0000_0007; tte_m[5] = mk_tte(2'd3, 64'h0000_0022_2200_0000, 1'b0, 1'b1);
    tag_m[7] = 64'h0000_4000_0000_0007; tte_m[7] = mk_tte(2'd1, 64'h0000_0033_3330_0000, 1'b0, 1'b0);
    run("R4 low wins", 64'h0000_4000_0000_1234, 13'h7, 1'b0, 1'b0);
    run("R4 larger page", 64'h0000_4000_0012_3456, 13'h7, 1'b0, 1'b0);
    tte_m[2][63] = 1'b0;
    run("R4 next low", 64'h0000_4000_0000_0010, 13'h7, 1'b0, 1'b0);

    // R5 R6 R7 permission sweep: priv x writable x user x write
    for (int p = 0; p < 16; p++) begin
      clear_tbl();
      tag_m[1] = 64'hFFFF_FFF0_0008_0000 | 64'h1FFF;
      tte_m[1] = mk_tte(2'd1, 64'h0000_00AB_CDE1_0000, p[0], p[1]);
      run($sformatf("R5 R6 R7 case%0d", p), 64'hFFFF_FFF0_0008_ABCD, 13'h1FFF, p[2], p[3]);
    end

    // R9 back-to-back requests with a gap
    clear_tbl();
    tag_m[0] = 64'h0000_0000_0000_2000; tte_m[0] = mk_tte(2'd0, 64'h0000_0000_0000_6000, 1'b0, 1'b1);
    run("R9 b2b hit", 64'h0000_0000_0000_2008, 13'h0, 1'b0, 1'b0);
    run("R9 b2b miss", 64'h0000_0000_0000_4008, 13'h0, 1'b0, 1'b0);
    run("R9 gap", 64'h0000_0000_0000_2008, 13'h0, 1'b0, 1'b0, 1'b0);
    run("R9 resume", 64'h0000_0000_0000_3FFF, 13'h0, 1'b1, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule